// File: doc/BRIEF.md
# Keyboard Scan Code History with Typematic Repeat Suppression

This block sits behind a keyboard byte receiver and keeps a short record of the scan code bytes a user has produced. Each decoded byte arrives on an 8-bit bus with a one-cycle valid strobe. The block shifts accepted bytes into a history word, with the newest byte at the least significant end. That word is meant to drive an eight-digit hexadecimal display, so the newest code appears in the two rightmost digits.

A released key arrives as the release prefix 0xF0 followed by the key's code, and the block records both bytes. A held key makes the keyboard resend its press code about every 100 ms. The block remembers the last press code and whether that key is still down, and it drops these resends, so only the first press is recorded. The extended prefix 0xE0 is shifted in like any other byte. Each byte that enters the history is marked by a one-cycle strobe.

Top module: `kbd_code_history`

## Requirements
- R1: A synchronous active-high reset clears the history to zero and holds the accepted strobe low. It also forgets the held key and any pending release, so a press code that was held before reset is accepted again after reset.
- R2: An accepted byte enters bits [7:0] of the history. Bits [31:8] take the previous bits [23:0], and the previous bits [31:24] are lost. The history and the strobe change at the first rising edge after the valid cycle.
- R3: The accepted strobe is high for exactly one cycle for each byte shifted in. This holds for bytes presented on back-to-back cycles.
- R4: The byte 0xF0 is always accepted and marks the next byte that is neither 0xF0 nor 0xE0 as a release code. A release code is always accepted.
- R5: A byte that is not 0xF0, not 0xE0 and not a release code is a press code. A press code equal to the remembered code while that key is marked down is dropped: no strobe, and the history is unchanged.
- R6: A release code clears the key-down mark, so the next press of the same key is accepted.
- R7: A press code that differs from the remembered code is accepted and becomes the remembered code, with the key marked down.
- R8: The byte 0xE0 is always accepted. It changes neither the remembered key state nor a pending release mark.
- R9: Pressing and releasing the key with code 0x29 leaves history bits [23:0] equal to 0x29F029.
- R10: While valid is low, the history holds its value and the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | One-cycle strobe qualifying code_byte |
| code_byte | input | 8 | Decoded scan code byte |
| history | output | 32 | Last four accepted bytes, newest in [7:0] |
| code_accepted | output | 1 | One-cycle strobe for each byte shifted into history |

## Verification
The bench sends a key press followed by several resends. A design without the repeat filter would show the code several times in the history and raise extra strobes. The bench re-presses a key just after releasing it, and a design that kept the key-down mark across the release would lose that second press. Extended sequences check that 0xE0 neither clears nor arms the release state. A broken design would then drop the extended key's release code or record its resends. The bench also checks that reset wipes the held-key memory, presents bytes back to back, and runs enough bytes through to push the oldest byte out of the top of the history.

// File: rtl/kch_pkg.sv
package kch_pkg;

   // Role of one incoming byte, decided from its value and the pending-release state
   typedef enum logic [1:0] {
      KC_PRESS      = 2'd0,
      KC_RELEASE    = 2'd1,
      KC_REL_PREFIX = 2'd2,
      KC_EXT_PREFIX = 2'd3
   } code_kind_e;

endpackage

// File: rtl/kch_decode.sv
module kch_decode
   import kch_pkg::*;
#(
   parameter int unsigned           DATA_W     = 8,
   parameter logic [DATA_W-1:0]     REL_PREFIX = 8'hF0,
   parameter logic [DATA_W-1:0]     EXT_PREFIX = 8'hE0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output code_kind_e        kind,
   output logic              rel_pending
);

   logic pend_q;

   always_comb begin
      if (in_byte == REL_PREFIX)      kind = KC_REL_PREFIX;
      else if (in_byte == EXT_PREFIX) kind = KC_EXT_PREFIX;
      else if (pend_q)                kind = KC_RELEASE;
      else                            kind = KC_PRESS;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (in_valid) begin
         case (kind)
            KC_REL_PREFIX: pend_q <= 1'b1;
            KC_RELEASE:    pend_q <= 1'b0;
            default:       pend_q <= pend_q;
         endcase
      end
   end

   assign rel_pending = pend_q;

endmodule

// File: rtl/kch_repeat_filter.sv
module kch_repeat_filter
   import kch_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          FILTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  code_kind_e        kind,
   output logic              take,
   output logic              held_valid,
   output logic [DATA_W-1:0] held_code
);

   generate
      if (FILTER_EN) begin : g_filter
         logic              down_q;
         logic [DATA_W-1:0] code_q;
         logic              is_repeat;

         assign is_repeat = (kind == KC_PRESS) && down_q && (in_byte == code_q);
         assign take      = in_valid && !is_repeat;

         always_ff @(posedge clk) begin
            if (rst) begin
               down_q <= 1'b0;
               code_q <= '0;
            end else if (in_valid) begin
               if (kind == KC_PRESS && !is_repeat) begin
                  down_q <= 1'b1;
                  code_q <= in_byte;
               end else if (kind == KC_RELEASE) begin
                  down_q <= 1'b0;
               end
            end
         end

         assign held_valid = down_q;
         assign held_code  = code_q;
      end else begin : g_pass
         assign take       = in_valid;
         assign held_valid = 1'b0;
         assign held_code  = '0;
      end
   endgenerate

endmodule

// File: rtl/kch_history.sv
module kch_history #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned HIST_W = DATA_W * DEPTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] shift_in,
   output logic [HIST_W-1:0] hist_word
);

   logic [DATA_W-1:0] lane_q [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_lane
         logic [DATA_W-1:0] lane_d;
         if (i == 0) begin : g_head
            assign lane_d = shift_in;
         end else begin : g_body
            assign lane_d = lane_q[i-1];
         end

         always_ff @(posedge clk) begin
            if (rst)           lane_q[i] <= '0;
            else if (shift_en) lane_q[i] <= lane_d;
         end

         assign hist_word[i*DATA_W +: DATA_W] = lane_q[i];
      end
   endgenerate

endmodule

// File: rtl/kbd_code_history.sv
module kbd_code_history
   import kch_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       DEPTH      = 4,
   parameter logic [DATA_W-1:0] REL_PREFIX = 8'hF0,
   parameter logic [DATA_W-1:0] EXT_PREFIX = 8'hE0,
   parameter bit                FILTER_EN  = 1'b1,
   localparam int unsigned      HIST_W     = DATA_W * DEPTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              code_valid,
   input  logic [DATA_W-1:0] code_byte,
   output logic [HIST_W-1:0] history,
   output logic              code_accepted
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("kbd_code_history: DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("kbd_code_history: DATA_W must be at least 2");
      end
      if (REL_PREFIX == EXT_PREFIX) begin : g_bad_prefix
         $error("kbd_code_history: prefixes must differ");
      end
   endgenerate

   code_kind_e        kind;
   logic              break_pending;
   logic              take;
   logic              held_valid;
   logic [DATA_W-1:0] held_code;
   logic              acc_q;

   kch_decode #(
      .DATA_W     (DATA_W),
      .REL_PREFIX (REL_PREFIX),
      .EXT_PREFIX (EXT_PREFIX)
   ) u_decode (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (code_valid),
      .in_byte     (code_byte),
      .kind        (kind),
      .rel_pending (break_pending)
   );

   kch_repeat_filter #(
      .DATA_W    (DATA_W),
      .FILTER_EN (FILTER_EN)
   ) u_filter (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (code_valid),
      .in_byte    (code_byte),
      .kind       (kind),
      .take       (take),
      .held_valid (held_valid),
      .held_code  (held_code)
   );

   kch_history #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_hist (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (take),
      .shift_in  (code_byte),
      .hist_word (history)
   );

   always_ff @(posedge clk) begin
      if (rst) acc_q <= 1'b0;
      else     acc_q <= take;
   end

   assign code_accepted = acc_q;

endmodule

// File: rtl/kch_checks.sv
module kch_checks #(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       DEPTH      = 4,
   parameter logic [DATA_W-1:0] REL_PREFIX = 8'hF0,
   parameter logic [DATA_W-1:0] EXT_PREFIX = 8'hE0,
   localparam int unsigned      HIST_W     = DATA_W * DEPTH
) (
   input logic              clk,
   input logic              rst,
   input logic              code_valid,
   input logic [DATA_W-1:0] code_byte,
   input logic [HIST_W-1:0] history,
   input logic              code_accepted,
   input logic              held_valid,
   input logic [DATA_W-1:0] held_code,
   input logic              break_pending
);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (history == '0) && !code_accepted);

   p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      code_accepted |->
         (history[HIST_W-1:DATA_W] == $past(history[HIST_W-DATA_W-1:0])) &&
         (history[DATA_W-1:0] == $past(code_byte)));

   p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(code_valid) |-> !code_accepted);

   p_prefix_taken_r4: assert property (@(posedge clk) disable iff (rst)
      (code_valid && code_byte == REL_PREFIX) |=> code_accepted);

   p_drop_repeat_r5: assert property (@(posedge clk) disable iff (rst)
      (code_valid && held_valid && !break_pending && code_byte == held_code &&
       code_byte != REL_PREFIX && code_byte != EXT_PREFIX) |=> !code_accepted);

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !code_accepted |-> $stable(history));

endmodule

bind kbd_code_history kch_checks #(
   .DATA_W     (DATA_W),
   .DEPTH      (DEPTH),
   .REL_PREFIX (REL_PREFIX),
   .EXT_PREFIX (EXT_PREFIX)
) u_checks (
   .clk           (clk),
   .rst           (rst),
   .code_valid    (code_valid),
   .code_byte     (code_byte),
   .history       (history),
   .code_accepted (code_accepted),
   .held_valid    (held_valid),
   .held_code     (held_code),
   .break_pending (break_pending)
);

// File: tb/kbd_code_history_test.sv
`timescale 1ns/1ps
module kbd_code_history_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        code_valid = 1'b0;
   logic [7:0]  code_byte = 8'h00;
   logic [31:0] history;
   logic        code_accepted;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   kbd_code_history uut (
      .clk           (clk),
      .rst           (rst),
      .code_valid    (code_valid),
      .code_byte     (code_byte),
      .history       (history),
      .code_accepted (code_accepted)
   );

   // reference state built from the requirements
   logic [31:0] m_hist;
   logic [7:0]  m_code;
   logic        m_down;
   logic        m_pend;

   logic [31:0] exp_h[$];
   string       exp_r[$];

   function automatic bit model_step(input logic [7:0] b);
      bit t;
      if (b == 8'hF0) begin
         t = 1; m_pend = 1;                 // R4
      end else if (b == 8'hE0) begin
         t = 1;                             // R8
      end else if (m_pend) begin
         t = 1; m_pend = 0; m_down = 0;     // R4, R6
      end else if (m_down && b == m_code) begin
         t = 0;                             // R5
      end else begin
         t = 1; m_code = b; m_down = 1;     // R7
      end
      if (t) m_hist = {m_hist[23:0], b};   // R2
      return t;
   endfunction

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic settle(input string req);
      #1;
      checks++;
      if (exp_h.size() != 0) begin
         fails++;
         $display("FAIL %s: missing accept strobe, actual=0 expected=1 (%0d pending)", req, exp_h.size());
         exp_h.delete();
         exp_r.delete();
      end
      check32(req, history, m_hist);
   endtask

   task automatic send(input logic [7:0] b, input string req);
      if (model_step(b)) begin
         exp_h.push_back(m_hist);
         exp_r.push_back(req);
      end
      @(negedge clk);
      code_valid = 1'b1;
      code_byte  = b;
      @(negedge clk);
      code_valid = 1'b0;
      settle(req);
   endtask

   task automatic send2(input logic [7:0] a, input logic [7:0] b, input string req);
      if (model_step(a)) begin exp_h.push_back(m_hist); exp_r.push_back(req); end
      if (model_step(b)) begin exp_h.push_back(m_hist); exp_r.push_back(req); end
      @(negedge clk);
      code_valid = 1'b1;
      code_byte  = a;
      @(negedge clk);
      code_byte  = b;
      @(negedge clk);
      code_valid = 1'b0;
      settle(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      code_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_hist = '0; m_code = '0; m_down = 0; m_pend = 0;
      exp_h.delete();
      exp_r.delete();
   endtask

   // monitor: every strobe must match the oldest expected history word
   always @(negedge clk) begin
      if (!rst && code_accepted) begin
         checks++;
         if (exp_h.size() == 0) begin
            fails++;
            $display("FAIL R3/R5: unexpected accept strobe, actual=1 expected=0 history=%08h", history);
         end else begin
            logic [31:0] e;
            string r;
            e = exp_h.pop_front();
            r = exp_r.pop_front();
            if (history !== e) begin
               fails++;
               $display("FAIL %s: history at strobe actual=%08h expected=%08h", r, history, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R3: watchdog expired, actual=20000 cycles expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      check32("R1 reset history", history, 32'h0);
      check32("R1 reset strobe", {31'b0, code_accepted}, 32'h0);

      send(8'h29, "R2 first press");
      send(8'h29, "R5 resend dropped");
      send(8'h29, "R5 second resend dropped");
      send(8'hF0, "R4 release prefix");
      send(8'h29, "R4 release code");
      check32("R9 press-release pattern", {8'h00, history[23:0]}, 32'h0029F029);

      send(8'h29, "R6 re-press after release");
      send(8'h1C, "R7 new key");
      send(8'h29, "R7 old key after change");
      send(8'h29, "R5 new held key resend");

      send(8'hE0, "R8 extended prefix");
      send(8'h75, "R7 extended press");
      send(8'hE0, "R8 prefix on resend");
      send(8'h75, "R5 extended resend dropped");
      send(8'hE0, "R8 extended release prefix");
      send(8'hF0, "R4 prefix after extended");
      send(8'h75, "R4 extended release code");
      send(8'h75, "R6 extended re-press");

      send(8'hF0, "R4 prefix before extended");
      send(8'hE0, "R8 pending kept across extended");
      send(8'h75, "R8 release after extended");
      send(8'h75, "R6 press after release");

      send2(8'h11, 8'h22, "R3 back-to-back two keys");
      send2(8'h22, 8'h22, "R3 back-to-back repeat");
      check32("R2 oldest byte dropped", history, m_hist);

      repeat (6) @(negedge clk);
      #1;
      check32("R10 idle history", history, m_hist);
      check32("R10 idle strobe", {31'b0, code_accepted}, 32'h0);

      send(8'h5A, "R2 held key before reset");
      do_reset();
      #1;
      check32("R1 history cleared", history, 32'h0);
      send(8'h5A, "R1 held state forgotten");
      check32("R1 re-press recorded", history, 32'h0000005A);

      send(8'hF0, "R1 pending armed");
      do_reset();
      send(8'h5A, "R1 pending cleared");
      send(8'h5A, "R1 pending cleared then resend");

      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule